// File: doc/BRIEF.md
# Write-Once Flash Page Staging Buffer

This block holds one page of words on their way into flash. A loader writes words one at a time. Each write gives a word index within the page and a data word. The indices may arrive in any order. Each location takes only its first write. Any later write to a location that already holds data is dropped until the whole buffer is flushed. Next to each stored word the block keeps a written flag. The page-write path reads the full page image and the flag vector directly from registered outputs.

The buffer flushes itself in four ways:
- a reset, which is asynchronous and active low;
- a pulse reporting that a page write has finished;
- a clear request written by software;
- a nonvolatile data-memory (EEPROM) write that arrives while at least one word is loaded.

A flushed location reads as all ones, which is the same value as erased flash. When a flush and a load fall in the same cycle, the flush wins and the load is discarded.

Top module: `tpb_page_buffer`

## Requirements
- R1: While reset is asserted, and after it is released, every written flag is 0 and every word of `page_data` reads as all ones.
- R2: A load with `load_en`=1 stores `load_data` at index `load_idx`, and sets that index's flag. Both are visible on the outputs after the next rising clock edge. Indices may be loaded in any order.
- R3: A load to an index whose flag is already 1 has no effect. The first value and the flag stay as they were.
- R4: A `page_done` pulse clears every flag to 0 and sets every word to all ones at the next edge.
- R5: A `clear_req` pulse clears every flag and sets every word to all ones at the next edge.
- R6: An `eeprom_wr` pulse while at least one flag is 1 clears every flag and sets every word to all ones at the next edge. While no flag is set, `eeprom_wr` leaves the buffer free to accept a load in that same cycle.
- R7: When any flush of R4, R5 or R6 falls in the same cycle as a load, the load is discarded and the buffer ends up empty.
- R8: A load changes only the addressed word and its flag. Every other word and flag keeps its value.
- R9: Word i of the page occupies bits [i*WORD_W +: WORD_W] of `page_data`, and its flag is bit i of `word_valid`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| load_en | input | 1 | Load strobe for one word |
| load_idx | input | $clog2(PAGE_WORDS) | Word index within the page |
| load_data | input | WORD_W | Word to store |
| page_done | input | 1 | Page write finished; flush the buffer |
| clear_req | input | 1 | Software clear request; flush the buffer |
| eeprom_wr | input | 1 | EEPROM write; flushes the buffer if any word is loaded |
| page_data | output | PAGE_WORDS*WORD_W | Full page image, word i at [i*WORD_W +: WORD_W] |
| word_valid | output | PAGE_WORDS | Per-word written flags |

## Verification
The collision that matters is a load and a flush arriving in the same cycle. The bench raises `load_en` together with `page_done`, with `clear_req`, and with `eeprom_wr` while a word is loaded, and requires an empty page after the edge. It also pairs `eeprom_wr` with a load into an empty buffer; there the load must land, because no loading was in progress. Every case is judged by comparing the whole page and all flags against an arithmetic model of the requirements.

// File: rtl/tpb_pkg.sv
package tpb_pkg;

    // Reason the buffer is flushed in a given cycle, highest priority first.
    typedef enum logic [1:0] {
        FL_NONE      = 2'd0,
        FL_PAGE_DONE = 2'd1,
        FL_SW_CLEAR  = 2'd2,
        FL_EE_ABORT  = 2'd3
    } flush_cause_e;

endpackage

// File: rtl/tpb_flush_ctl.sv
module tpb_flush_ctl
    import tpb_pkg::*;
(
    input  logic         page_done_i,
    input  logic         clear_i,
    input  logic         eeprom_wr_i,
    input  logic         any_loaded_i,
    output flush_cause_e cause_o,
    output logic         flush_o
);

    always_comb begin
        cause_o = FL_NONE;
        if (page_done_i) begin
            cause_o = FL_PAGE_DONE;
        end else if (clear_i) begin
            cause_o = FL_SW_CLEAR;
        end else if (eeprom_wr_i && any_loaded_i) begin
            // An EEPROM write only aborts a load sequence that has begun.
            cause_o = FL_EE_ABORT;
        end
    end

    assign flush_o = (cause_o != FL_NONE);

endmodule

// File: rtl/tpb_slot.sv
module tpb_slot #(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush_i,
    input  logic              wr_i,
    input  logic [WORD_W-1:0] wr_data_i,
    output logic [WORD_W-1:0] data_o,
    output logic              valid_o
);

    typedef struct packed {
        logic [WORD_W-1:0] data;
        logic              valid;
    } slot_t;

    slot_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (flush_i) begin
            st_d.data  = '1;
            st_d.valid = 1'b0;
        end else if (wr_i && !st_q.valid) begin
            st_d.data  = wr_data_i;
            st_d.valid = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{data: '1, valid: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign data_o  = st_q.data;
    assign valid_o = st_q.valid;

    // A written word is frozen until the next flush.
    assert_write_once_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && !flush_i) |=> (valid_o && $stable(data_o)));

    // A flush leaves the slot empty and erased.
    assert_flush_erased_R1: assert property (@(posedge clk) disable iff (!rst_n)
        flush_i |=> (!valid_o && (data_o == '1)));

    // An empty slot stays untouched without a write.
    assert_idle_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!valid_o && !wr_i && !flush_i) |=> (!valid_o && $stable(data_o)));

endmodule

// File: rtl/tpb_page_buffer.sv
module tpb_page_buffer
    import tpb_pkg::*;
#(
    parameter int PAGE_WORDS = 32,
    parameter int WORD_W     = 16,
    localparam int IDX_W     = $clog2(PAGE_WORDS),
    localparam int PAGE_W    = PAGE_WORDS * WORD_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_en,
    input  logic [IDX_W-1:0]  load_idx,
    input  logic [WORD_W-1:0] load_data,
    input  logic              page_done,
    input  logic              clear_req,
    input  logic              eeprom_wr,
    output logic [PAGE_W-1:0] page_data,
    output logic [PAGE_WORDS-1:0] word_valid
);

    flush_cause_e cause;
    logic         flush;
    logic         any_loaded;

    assign any_loaded = |word_valid;

    tpb_flush_ctl u_flush (
        .page_done_i  (page_done),
        .clear_i      (clear_req),
        .eeprom_wr_i  (eeprom_wr),
        .any_loaded_i (any_loaded),
        .cause_o      (cause),
        .flush_o      (flush)
    );

    for (genvar i = 0; i < PAGE_WORDS; i++) begin : g_slot
        logic sel;
        assign sel = load_en && (load_idx == IDX_W'(i));

        tpb_slot #(.WORD_W(WORD_W)) u_slot (
            .clk       (clk),
            .rst_n     (rst_n),
            .flush_i   (flush),
            .wr_i      (sel),
            .wr_data_i (load_data),
            .data_o    (page_data[i*WORD_W +: WORD_W]),
            .valid_o   (word_valid[i])
        );
    end

    assert_page_done_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
        page_done |=> (word_valid == '0));

    assert_sw_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        clear_req |=> (word_valid == '0));

    assert_ee_abort_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (eeprom_wr && (word_valid != '0)) |=> (word_valid == '0));

    assert_load_sets_flag_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (load_en && !page_done && !clear_req && !(eeprom_wr && (word_valid != '0)))
            |=> word_valid[$past(load_idx)]);

    assert_single_flag_rise_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !load_en |=> ($countones(word_valid & ~$past(word_valid)) == 0));

endmodule

// File: tb/tb_tpb_page_buffer.sv
module tb_tpb_page_buffer;

    localparam int CLK_PERIOD = 10;
    localparam int PW   = 32;
    localparam int WW   = 16;
    localparam int IW   = $clog2(PW);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          load_en = 1'b0;
    logic [IW-1:0] load_idx = '0;
    logic [WW-1:0] load_data = '0;
    logic          page_done = 1'b0;
    logic          clear_req = 1'b0;
    logic          eeprom_wr = 1'b0;
    logic [PW*WW-1:0] page_data;
    logic [PW-1:0]    word_valid;

    int n_tests = 0;
    int n_fail  = 0;

    logic [WW-1:0] exp_data  [PW];
    logic          exp_valid [PW];

    always #(CLK_PERIOD/2) clk = ~clk;

    tpb_page_buffer #(.PAGE_WORDS(PW), .WORD_W(WW)) dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_en    (load_en),
        .load_idx   (load_idx),
        .load_data  (load_data),
        .page_done  (page_done),
        .clear_req  (clear_req),
        .eeprom_wr  (eeprom_wr),
        .page_data  (page_data),
        .word_valid (word_valid)
    );

    function automatic logic [WW-1:0] pat(int idx, int seed);
        return WW'((idx * 16'h0101) ^ (seed * 16'h1357) ^ 16'h0A50);
    endfunction

    task automatic model_clear();
        for (int i = 0; i < PW; i++) begin
            exp_data[i]  = '1;
            exp_valid[i] = 1'b0;
        end
    endtask

    // Compare the whole page and every flag; word i lives at [i*WW +: WW] (R9).
    task automatic check_page(string tag);
        for (int i = 0; i < PW; i++) begin
            n_tests++;
            if (page_data[i*WW +: WW] !== exp_data[i] || word_valid[i] !== exp_valid[i]) begin
                n_fail++;
                $display("FAIL %s R9 word %0d: got data %h valid %b, expected data %h valid %b",
                         tag, i, page_data[i*WW +: WW], word_valid[i], exp_data[i], exp_valid[i]);
            end
        end
    endtask

    // One clock: drive at negedge, let the posedge register, come back to negedge.
    task automatic step(logic ld, int idx, logic [WW-1:0] d, logic pd, logic clr, logic ee);
        logic any;
        load_en = ld; load_idx = IW'(idx); load_data = d;
        page_done = pd; clear_req = clr; eeprom_wr = ee;
        any = 1'b0;
        for (int i = 0; i < PW; i++) any |= exp_valid[i];
        @(posedge clk);
        @(negedge clk);
        load_en = 1'b0; page_done = 1'b0; clear_req = 1'b0; eeprom_wr = 1'b0;
        if (pd || clr || (ee && any)) begin
            model_clear();
        end else if (ld && !exp_valid[idx]) begin
            exp_data[idx]  = d;
            exp_valid[idx] = 1'b1;
        end
    endtask

    task automatic load(int idx, logic [WW-1:0] d);
        step(1'b1, idx, d, 1'b0, 1'b0, 1'b0);
    endtask

    initial begin
        model_clear();
        repeat (3) @(negedge clk);
        check_page("R1 during reset");
        rst_n = 1'b1;
        @(negedge clk);
        check_page("R1 after reset");

        // R2 R8: fill every index in a scrambled order, checking the page each time.
        for (int k = 0; k < PW; k++) begin
            int idx = (k * 13 + 5) % PW;
            load(idx, pat(idx, 1));
            check_page("R2 R8 scrambled fill");
        end

        // R3: second writes to every location are ignored.
        for (int k = 0; k < PW; k++) begin
            load(PW - 1 - k, pat(k, 7));
        end
        check_page("R3 rewrite ignored");

        // R4: page write done flushes.
        step(1'b0, 0, '0, 1'b1, 1'b0, 1'b0);
        check_page("R4 page done");

        // R5: software clear flushes a half-filled page.
        for (int k = 0; k < PW; k += 2) load(k, pat(k, 2));
        check_page("R2 even fill");
        step(1'b0, 0, '0, 1'b0, 1'b1, 1'b0);
        check_page("R5 clear request");

        // R6: EEPROM write during loading discards the data.
        for (int k = 1; k < PW; k += 3) load(k, pat(k, 3));
        step(1'b0, 0, '0, 1'b0, 1'b0, 1'b1);
        check_page("R6 eeprom abort");

        // R6: EEPROM write with an empty buffer does not block a load in that cycle.
        step(1'b1, 9, pat(9, 4), 1'b0, 1'b0, 1'b1);
        check_page("R6 eeprom while empty");

        // R7: a flush beats a load in the same cycle, for each flush source.
        step(1'b1, 3, pat(3, 5), 1'b1, 1'b0, 1'b0);
        check_page("R7 load with page done");
        load(4, pat(4, 5));
        step(1'b1, 5, pat(5, 5), 1'b0, 1'b1, 1'b0);
        check_page("R7 load with clear");
        load(6, pat(6, 5));
        step(1'b1, 7, pat(7, 5), 1'b0, 1'b0, 1'b1);
        check_page("R7 load with eeprom abort");

        // R1: reset in mid-load empties the page.
        load(0, pat(0, 6));
        load(PW - 1, pat(PW - 1, 6));
        check_page("R2 boundary indices");
        rst_n = 1'b0;
        @(negedge clk);
        model_clear();
        check_page("R1 reset mid-load");
        rst_n = 1'b1;
        @(negedge clk);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: got timeout, expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule